// File: doc/BRIEF.md
# Hazard interlock and operand forwarding control

This block is the dependence control for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it compares the two source register numbers of the instruction in decode with the destination register numbers of the three older instructions in execute, memory and writeback. From these comparisons it decides two things. The first is whether fetch and decode must hold for a cycle while a bubble enters execute. The second is which value each ALU operand should take once the decoding instruction reaches execute: the register file value, the result leaving the execute stage, or the result leaving the memory stage.

The block has no state and no clock. Its forwarding selects are meant to be captured into the decode/execute pipeline latch together with the instruction. A producer now in execute has its result in the execute/memory latch one cycle later. A producer now in memory has its result (ALU value or load data) in the memory/writeback latch one cycle later. A producer now in writeback writes the register file in the first half of the cycle, and decode reads it in the second half, so no bypass is needed for it. The only dependence that forwarding cannot cover is a load in execute that feeds the decoding instruction. That case costs exactly one bubble. After the bubble the load sits in memory and the normal forwarding path supplies its data.

Top module: `hazard_unit`

## Requirements
- R1: With no older instruction writing a register, pc_we and ifid_we are 1, idex_bubble is 0, and both forward selects are 2'b00 (register file).
- R2: If the execute-stage instruction writes a nonzero register equal to a used decode source and is not a load, that operand's select is 2'b10 (execute/memory result) and no stall occurs.
- R3: If the memory-stage instruction writes a nonzero register equal to a used decode source, and no execute-stage producer matches that source, the operand's select is 2'b01 (memory/writeback result). This holds for loads and for ALU producers alike.
- R4: If both the execute-stage and memory-stage destinations match the same used source, the younger producer wins and the select is 2'b10.
- R5: A match against the writeback-stage destination alone leaves the select at 2'b00, because the register file writes before it reads within a cycle.
- R6: A destination of register 0 never causes a forward or a stall, even with its write-enable set.
- R7: A destination whose write-enable is 0 (for example a store) never causes a forward or a stall.
- R8: A decode source whose used flag is 0 always gets select 2'b00 and never causes a stall.
- R9: A load in execute whose nonzero destination, with write-enable set, equals a used decode source drives pc_we=0, ifid_we=0 and idex_bubble=1. A load in execute that matches no used source causes no stall.
- R10: While a stall is asserted, both forward selects are 2'b00.
- R11: The two operands are resolved independently, so each can receive a different select in the same cycle.
- R12: A load that has moved on to the memory stage no longer stalls a matching consumer and is forwarded with select 2'b01, so a load-use pair costs exactly one bubble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_src_a | input | REG_W | First source register of the decoding instruction |
| dec_src_a_en | input | 1 | First source is actually read |
| dec_src_b | input | REG_W | Second source register of the decoding instruction |
| dec_src_b_en | input | 1 | Second source is actually read |
| ex_dst | input | REG_W | Destination register of the execute-stage instruction |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_ld | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | REG_W | Destination register of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | REG_W | Destination register of the writeback-stage instruction |
| wb_wr | input | 1 | Writeback-stage instruction writes a register |
| pc_we | output | 1 | Program counter may advance |
| ifid_we | output | 1 | Fetch/decode latch may load |
| idex_bubble | output | 1 | Load a no-op into the decode/execute latch |
| fwd_sel_a | output | 2 | Forward select for operand A: 00 reg file, 10 exec/mem, 01 mem/wb |
| fwd_sel_b | output | 2 | Forward select for operand B, same encoding |

## Verification
The block is driven with producers placed one at a time in execute, memory and writeback against each source. This separates the three stage distances and shows that only the two nearer ones forward. The same patterns are then repeated with register 0, with a cleared write-enable and with an unused source, to show that each qualifier alone suppresses a match. Overlapping producers on one register test the youngest-first priority, and split producers on the two operands test their independence. A load followed by a consumer is stepped through the pipeline to show a single bubble and then a memory-stage forward. Randomized vectors over a small register range, with frequent collisions, finish the coverage of mixed cases.

// File: rtl/hz_pkg.sv
package hz_pkg;

  localparam int HZ_REG_W = 5;

  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_MEMWB = 2'b01,
    FWD_EXMEM = 2'b10
  } fwd_sel_e;

endpackage

// File: rtl/hz_match.sv
// Qualified equality compare of one decode source against every older
// stage destination. Bit 0 is the youngest producer (execute stage).
module hz_match #(
  parameter int REG_W      = hz_pkg::HZ_REG_W,
  parameter int NUM_STAGES = 3
) (
  input  logic [NUM_STAGES-1:0][REG_W-1:0] dst,
  input  logic [NUM_STAGES-1:0]            dst_wen,
  input  logic [REG_W-1:0]                 src,
  input  logic                             src_used,
  output logic [NUM_STAGES-1:0]            hit
);

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_cmp
    logic writes_real;
    assign writes_real = dst_wen[g] && (dst[g] != '0);
    assign hit[g]      = src_used && writes_real && (dst[g] == src);
  end

endmodule

// File: rtl/hz_loaduse.sv
// Load-use interlock: one cycle of hold while a load in execute feeds decode.
module hz_loaduse #(
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0] ex_hit,
  input  logic               ex_ld,
  output logic               stall
);

  always_comb begin
    stall = ex_ld && (|ex_hit);
  end

endmodule

// File: rtl/hz_fwd_pick.sv
// Youngest-first priority over the per-stage hits of one operand.
module hz_fwd_pick #(
  parameter int NUM_STAGES = 3
) (
  input  logic [NUM_STAGES-1:0] hit,
  input  logic                  stall,
  output hz_pkg::fwd_sel_e      sel
);
  import hz_pkg::*;

  always_comb begin
    if (stall)        sel = FWD_RF;
    else if (hit[0])  sel = FWD_EXMEM;
    else if (hit[1])  sel = FWD_MEMWB;
    else if (hit[2])  sel = FWD_RF;   // write-then-read register file covers it
    else              sel = FWD_RF;
  end

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int REG_W = hz_pkg::HZ_REG_W
) (
  input  logic [REG_W-1:0] dec_src_a,
  input  logic             dec_src_a_en,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic             dec_src_b_en,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wr,
  input  logic             ex_ld,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             idex_bubble,
  output logic [1:0]       fwd_sel_a,
  output logic [1:0]       fwd_sel_b
);
  import hz_pkg::*;

  localparam int NUM_STAGES = 3;
  localparam int NUM_SRC    = 2;

  logic [NUM_STAGES-1:0][REG_W-1:0] dst_vec;
  logic [NUM_STAGES-1:0]            wen_vec;
  logic [NUM_SRC-1:0][REG_W-1:0]    src_vec;
  logic [NUM_SRC-1:0]               src_en;
  logic [NUM_SRC-1:0][NUM_STAGES-1:0] hit;
  logic [NUM_SRC-1:0]               ex_hit;
  fwd_sel_e                         sel [NUM_SRC];
  logic                             stall;

  assign dst_vec = {wb_dst, mem_dst, ex_dst};
  assign wen_vec = {wb_wr, mem_wr, ex_wr};
  assign src_vec = {dec_src_b, dec_src_a};
  assign src_en  = {dec_src_b_en, dec_src_a_en};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    hz_match #(.REG_W(REG_W), .NUM_STAGES(NUM_STAGES)) u_match (
      .dst      (dst_vec),
      .dst_wen  (wen_vec),
      .src      (src_vec[s]),
      .src_used (src_en[s]),
      .hit      (hit[s])
    );
    assign ex_hit[s] = hit[s][0];

    hz_fwd_pick #(.NUM_STAGES(NUM_STAGES)) u_pick (
      .hit   (hit[s]),
      .stall (stall),
      .sel   (sel[s])
    );
  end

  hz_loaduse #(.NUM_SRC(NUM_SRC)) u_loaduse (
    .ex_hit (ex_hit),
    .ex_ld  (ex_ld),
    .stall  (stall)
  );

  assign pc_we       = !stall;
  assign ifid_we     = !stall;
  assign idex_bubble = stall;
  assign fwd_sel_a   = sel[0];
  assign fwd_sel_b   = sel[1];

endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int REG_W = hz_pkg::HZ_REG_W
) (
  input logic [REG_W-1:0] dec_src_a,
  input logic             dec_src_a_en,
  input logic [REG_W-1:0] dec_src_b,
  input logic             dec_src_b_en,
  input logic [REG_W-1:0] ex_dst,
  input logic             ex_wr,
  input logic             ex_ld,
  input logic             pc_we,
  input logic             ifid_we,
  input logic             idex_bubble,
  input logic [1:0]       fwd_sel_a,
  input logic [1:0]       fwd_sel_b
);

  always_comb begin
    AST_HOLD_TOGETHER: assert (pc_we == ifid_we && idex_bubble == !pc_we)
      else $error("hold and bubble disagree"); // R9
    AST_STALL_NEEDS_LOAD: assert (!idex_bubble || (ex_ld && ex_wr && ex_dst != '0))
      else $error("stall without a real load in execute"); // R9
    AST_STALL_SEL_RF: assert (!idex_bubble || (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00))
      else $error("forward select active during stall"); // R10
    AST_SEL_LEGAL: assert (fwd_sel_a != 2'b11 && fwd_sel_b != 2'b11)
      else $error("illegal forward select"); // R2
    AST_ZERO_SRC_A: assert (dec_src_a != '0 || fwd_sel_a == 2'b00)
      else $error("register 0 forwarded on operand A"); // R6
    AST_ZERO_SRC_B: assert (dec_src_b != '0 || fwd_sel_b == 2'b00)
      else $error("register 0 forwarded on operand B"); // R6
    AST_UNUSED_A: assert (dec_src_a_en || fwd_sel_a == 2'b00)
      else $error("unused operand A forwarded"); // R8
    AST_UNUSED_B: assert (dec_src_b_en || fwd_sel_b == 2'b00)
      else $error("unused operand B forwarded"); // R8
  end

endmodule

bind hazard_unit hazard_unit_chk #(.REG_W(REG_W)) u_chk (
  .dec_src_a    (dec_src_a),
  .dec_src_a_en (dec_src_a_en),
  .dec_src_b    (dec_src_b),
  .dec_src_b_en (dec_src_b_en),
  .ex_dst       (ex_dst),
  .ex_wr        (ex_wr),
  .ex_ld        (ex_ld),
  .pc_we        (pc_we),
  .ifid_we      (ifid_we),
  .idex_bubble  (idex_bubble),
  .fwd_sel_a    (fwd_sel_a),
  .fwd_sel_b    (fwd_sel_b)
);

// File: tb/hazard_unit_test.sv
`timescale 1ns/1ps
module hazard_unit_test;

  localparam int W = 5;

  logic clk;
  logic rst_n;

  logic [W-1:0] sa, sb, exd, memd, wbd;
  logic         sa_en, sb_en, exw, exl, memw, wbw;
  logic         pc_we, ifid_we, bub;
  logic [1:0]   fa, fb;

  typedef struct {
    logic       pcwe;
    logic       ifwe;
    logic       bub;
    logic [1:0] fa;
    logic [1:0] fb;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;

  hazard_unit #(.REG_W(W)) uut (
    .dec_src_a (sa), .dec_src_a_en (sa_en),
    .dec_src_b (sb), .dec_src_b_en (sb_en),
    .ex_dst (exd), .ex_wr (exw), .ex_ld (exl),
    .mem_dst (memd), .mem_wr (memw),
    .wb_dst (wbd), .wb_wr (wbw),
    .pc_we (pc_we), .ifid_we (ifid_we), .idex_bubble (bub),
    .fwd_sel_a (fa), .fwd_sel_b (fb)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // Expected behaviour written from the requirement list
  function automatic logic [1:0] pick(bit st, bit he, bit hm);
    if (st)      return 2'b00;   // R10
    else if (he) return 2'b10;   // R2, R4
    else if (hm) return 2'b01;   // R3
    else         return 2'b00;   // R1, R5
  endfunction

  task automatic apply(input logic [W-1:0] a, input bit ae,
                       input logic [W-1:0] b, input bit be,
                       input logic [W-1:0] e, input bit ew, input bit el,
                       input logic [W-1:0] m, input bit mw,
                       input logic [W-1:0] w, input bit ww,
                       input string tag);
    exp_t x;
    bit hea, heb, hma, hmb, st;
    @(negedge clk);
    sa = a; sa_en = ae; sb = b; sb_en = be;
    exd = e; exw = ew; exl = el; memd = m; memw = mw; wbd = w; wbw = ww;
    hea = ae && ew && e != 0 && e == a;
    heb = be && ew && e != 0 && e == b;
    hma = ae && mw && m != 0 && m == a;
    hmb = be && mw && m != 0 && m == b;
    st  = el && (hea || heb);
    x.pcwe = !st; x.ifwe = !st; x.bub = st;
    x.fa = pick(st, hea, hma);
    x.fb = pick(st, heb, hmb);
    x.tag = tag;
    q.push_back(x);
  endtask

  // Monitor: compare away from the clock edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        n_tests++;
        if (pc_we !== x.pcwe || ifid_we !== x.ifwe || bub !== x.bub ||
            fa !== x.fa || fb !== x.fb) begin
          n_fail++;
          $display("FAIL %s: got pc=%b if=%b bub=%b fa=%b fb=%b exp pc=%b if=%b bub=%b fa=%b fb=%b",
                   x.tag, pc_we, ifid_we, bub, fa, fb, x.pcwe, x.ifwe, x.bub, x.fa, x.fb);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    sa = 0; sb = 0; exd = 0; memd = 0; wbd = 0;
    sa_en = 0; sb_en = 0; exw = 0; exl = 0; memw = 0; wbw = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;

    // R1: idle pipeline
    apply(0,0, 0,0, 0,0,0, 0,0, 0,0, "R1 idle");
    apply(3,1, 4,1, 7,0,0, 8,0, 9,0, "R1 no writers");
    // R2: execute-stage ALU producer
    apply(5,1, 6,1, 5,1,0, 0,0, 0,0, "R2 ex->a");
    apply(5,1, 6,1, 6,1,0, 0,0, 0,0, "R2 ex->b");
    // R3: memory-stage producer, ALU and load
    apply(7,1, 2,1, 0,0,0, 7,1, 0,0, "R3 mem->a");
    apply(7,1, 2,1, 0,0,0, 2,1, 0,0, "R3 mem->b");
    // R4: youngest wins
    apply(9,1, 9,1, 9,1,0, 9,1, 0,0, "R4 ex over mem");
    // R5: writeback only
    apply(4,1, 4,1, 0,0,0, 0,0, 4,1, "R5 wb via regfile");
    // R6: register zero
    apply(0,1, 0,1, 0,1,1, 0,1, 0,1, "R6 zero dst");
    // R7: no write-enable (store)
    apply(5,1, 5,1, 5,0,1, 5,0, 5,0, "R7 no wen");
    // R8: unused sources
    apply(5,0, 6,0, 5,1,1, 6,1, 0,0, "R8 unused");
    apply(5,1, 6,0, 6,1,1, 0,0, 0,0, "R8 unused b vs load");
    // R9: load-use stall on each operand
    apply(3,1, 1,1, 3,1,1, 0,0, 0,0, "R9 load-use a");
    apply(1,1, 3,1, 3,1,1, 0,0, 0,0, "R9 load-use b");
    apply(1,1, 2,1, 3,1,1, 0,0, 0,0, "R9 load no match");
    // R10: stall clears selects despite mem match on other operand
    apply(3,1, 8,1, 3,1,1, 8,1, 0,0, "R10 stall sel rf");
    // R11: independent operands
    apply(10,1, 11,1, 10,1,0, 11,1, 0,0, "R11 a=ex b=mem");
    apply(12,1, 10,1, 10,1,0, 12,1, 0,0, "R11 a=mem b=ex");
    // R12: load-use walk: stall, bubble moves, load in memory forwards
    apply(6,1, 0,0, 6,1,1, 0,0, 0,0, "R12 step1 stall");
    apply(6,1, 0,0, 0,0,0, 6,1, 0,0, "R12 step2 forward");
    apply(6,1, 0,0, 0,0,0, 0,0, 6,1, "R12 step3 regfile");

    // Mixed random cases over a small register range
    for (int i = 0; i < 300; i++) begin
      apply($urandom_range(0,3), 1'($urandom), $urandom_range(0,3), 1'($urandom),
            $urandom_range(0,3), 1'($urandom), 1'($urandom),
            $urandom_range(0,3), 1'($urandom),
            $urandom_range(0,3), 1'($urandom), "R11 random mix");
    end

    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule